// File: doc/BRIEF.md
# Lane-Partitioned Vector Shift and Absolute-Value Unit

This block applies one operation to every lane of a wide vector in a single step. The vector is split into independent lanes of 8, 16 or 32 bits, chosen at runtime by an element-size code. The available operations are a left shift, an arithmetic right shift, a logical right shift and a two's-complement absolute value. All three shifts use one scalar shift count that applies to every lane.

A single data path serves every lane size. No bit shifted out of one lane, and no sign bit, ever reaches a neighbouring lane. A typical use is bit-depth reduction: 10-bit samples held in 16-bit lanes become 8-bit samples with one logical right shift by two. Other uses are scaling by powers of two and taking magnitudes of signed samples. The result is registered. It appears, together with a valid flag, one clock after an accepted input.

Top module: `simd_lane_alu`

## Requirements
- R1: Opcode 0 shifts each lane left by the effective count. Vacated low bits are zero, and bits pushed past the lane's top are lost.
- R2: Opcode 2 shifts each lane right and fills the vacated high bits with zeros.
- R3: Opcode 1 shifts each lane right and fills the vacated high bits with that lane's own sign bit.
- R4: Opcode 3 replaces each lane with its two's-complement absolute value. The shift count has no effect in this mode.
- R5: The absolute value of a lane's most negative value (0x80, 0x8000 or 0x80000000) is that same value. It does not saturate.
- R6: The effective shift count is shiftAmt modulo the lane width: bits [2:0] for bytes, [3:0] for halfwords and [4:0] for words.
- R7: Size code 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes. Lane k occupies bits [k*w+w-1 : k*w]. In every size, no lane's result depends on another lane's bits.
- R8: vecOut and validOut update on the clock edge after an input is presented with validIn high. validOut goes high for exactly those cycles. When validIn is low, vecOut keeps its previous value.
- R9: While rst (synchronous, active high) is asserted, validOut is low and vecOut is all zeros.
- R10: A logical right shift by 2 on 16-bit lanes turns 10-bit samples into their upper 8 bits. Neighbouring lanes are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Input operands valid |
| opSel | input | 2 | Operation: 0 left shift, 1 arithmetic right, 2 logical right, 3 absolute value |
| sizeSel | input | 2 | Lane size: 0 byte, 1 halfword, 2/3 word |
| shiftAmt | input | 5 | Scalar shift count, reduced modulo lane width |
| vecIn | input | W | Source vector |
| validOut | output | 1 | Result valid, one cycle after validIn |
| vecOut | output | W | Result vector |

## Verification
Random vectors are run through every pairing of lane size and opcode. A scalar lane-by-lane model exposes any wrong fill bit, wrong count reduction or lane-select error. All-ones vectors under left and logical right shifts separate a correct lane boundary from one that lets bits spill into a neighbour. Lanes holding only the most negative value separate wrapping from saturating absolute value. Counts at and above the lane width show whether the count is reduced per size. An idle stretch with changing data confirms that the output register holds its value.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int LANE_MAX = 32;
  localparam int AMT_W = $clog2(LANE_MAX);
  localparam int N_SIZES = 3;

  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_ASR = 2'd1,
    OP_LSR = 2'd2,
    OP_ABS = 2'd3
  } op_e;

  typedef struct packed {
    logic       load;
    logic       shl;
    logic       asr;
    logic       lsr;
    logic       abs;
    logic [N_SIZES-1:0] size1h;
  } strobes_t;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int LW = 16,
  localparam int SW = $clog2(LW)
) (
  input  logic [LW-1:0] a,
  input  logic [SW-1:0] amt,
  input  logic          doShl,
  input  logic          doAsr,
  input  logic          doLsr,
  input  logic          doAbs,
  output logic [LW-1:0] y
);
  logic [LW-1:0] shlRes, asrRes, lsrRes, absRes;

  always_comb begin
    shlRes = a << amt;
    lsrRes = a >> amt;
    asrRes = $unsigned($signed(a) >>> amt);
    absRes = a[LW-1] ? (~a + LW'(1)) : a;
    y = '0;
    if (doShl)      y = shlRes;
    else if (doAsr) y = asrRes;
    else if (doLsr) y = lsrRes;
    else if (doAbs) y = absRes;
  end
endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     validIn,
  input  logic [1:0] opSel,
  input  logic [1:0] sizeSel,
  output strobes_t stb,
  output logic     validOut
);
  always_comb begin
    stb = '0;
    stb.load = validIn;
    unique case (op_e'(opSel))
      OP_SHL: stb.shl = 1'b1;
      OP_ASR: stb.asr = 1'b1;
      OP_LSR: stb.lsr = 1'b1;
      OP_ABS: stb.abs = 1'b1;
    endcase
    case (sizeSel)
      2'd0:    stb.size1h = 3'b001;
      2'd1:    stb.size1h = 3'b010;
      default: stb.size1h = 3'b100;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end
endmodule

// File: rtl/simd_lanes.sv
module simd_lanes
  import simd_pkg::*;
#(
  parameter int W = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         stb,
  input  logic [AMT_W-1:0] amt,
  input  logic [W-1:0]     vecIn,
  output logic [W-1:0]     vecOut
);
  logic [N_SIZES-1:0][W-1:0] perSize;
  logic [W-1:0] selRes;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int NL = W / LW;
    localparam int SW = $clog2(LW);
    for (genvar l = 0; l < NL; l++) begin : g_lane
      simd_lane #(.LW(LW)) u_lane (
        .a     (vecIn[l*LW +: LW]),
        .amt   (amt[SW-1:0]),
        .doShl (stb.shl),
        .doAsr (stb.asr),
        .doLsr (stb.lsr),
        .doAbs (stb.abs),
        .y     (perSize[s][l*LW +: LW])
      );
    end
  end

  always_comb begin
    selRes = '0;
    for (int s = 0; s < N_SIZES; s++)
      if (stb.size1h[s]) selRes = perSize[s];
  end

  always_ff @(posedge clk) begin
    if (rst)           vecOut <= '0;
    else if (stb.load) vecOut <= selRes;
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int W = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             validIn,
  input  logic [1:0]       opSel,
  input  logic [1:0]       sizeSel,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic [W-1:0]     vecIn,
  output logic             validOut,
  output logic [W-1:0]     vecOut
);
  strobes_t stb;

  simd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .opSel    (opSel),
    .sizeSel  (sizeSel),
    .stb      (stb),
    .validOut (validOut)
  );

  simd_lanes #(.W(W)) u_lanes (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .amt    (shiftAmt),
    .vecIn  (vecIn),
    .vecOut (vecOut)
  );
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int W = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic       validIn,
  input logic [1:0] opSel,
  input logic [1:0] sizeSel,
  input logic [4:0] shiftAmt,
  input logic [W-1:0] vecIn,
  input logic       validOut,
  input logic [W-1:0] vecOut
);
  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (validOut == $past(validIn)));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(validIn)) |-> $stable(vecOut));

  // R1
  shl_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(validIn && opSel == 2'd0 && sizeSel == 2'd0 && shiftAmt[2:0] != 3'd0))
    |-> (vecOut[0] == 1'b0 && vecOut[8] == 1'b0));

  // R2
  lsr_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(validIn && opSel == 2'd2 && sizeSel == 2'd1 && shiftAmt[3:0] != 4'd0))
    |-> (vecOut[15] == 1'b0 && vecOut[31] == 1'b0));

  // R3
  asr_sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(validIn && opSel == 2'd1 && sizeSel == 2'd0))
    |-> (vecOut[7] == $past(vecIn[7])));

  // R5
  abs_word_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(validIn && opSel == 2'd3 && sizeSel == 2'd2))
    |-> (vecOut[31] == 1'b0 || vecOut[31:0] == 32'h8000_0000));

  // R9
  always @(posedge clk) begin
    if (!rst && $past(rst) && !$past(validIn))
      reset_clear_chk: assert (validOut == 1'b0 && vecOut == '0);
  end
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .validIn(validIn), .opSel(opSel), .sizeSel(sizeSel),
  .shiftAmt(shiftAmt), .vecIn(vecIn), .validOut(validOut), .vecOut(vecOut)
);

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb;
  localparam int W = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic [1:0] opSel = '0;
  logic [1:0] sizeSel = '0;
  logic [4:0] shiftAmt = '0;
  logic [W-1:0] vecIn = '0;
  logic validOut;
  logic [W-1:0] vecOut;

  always #2 clk = ~clk;

  simd_lane_alu #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .validIn(validIn), .opSel(opSel), .sizeSel(sizeSel),
    .shiftAmt(shiftAmt), .vecIn(vecIn), .validOut(validOut), .vecOut(vecOut)
  );

  typedef struct {
    logic [W-1:0] exp;
    string tag;
  } item_t;

  item_t q[$];
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] refModel(logic [W-1:0] a, logic [4:0] amt,
                                            logic [1:0] op, logic [1:0] sz);
    int lw = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    longint mask = (longint'(1) << lw) - 1;
    int sh = int'(amt) % lw;
    logic [W-1:0] res = '0;
    for (int l = 0; l < W / lw; l++) begin
      logic [W-1:0] t = a >> (l * lw);
      longint e = longint'(t[31:0]) & mask;
      longint r;
      logic [W-1:0] rv = '0;
      case (op)
        2'd0: r = (e << sh) & mask;
        2'd1: begin
          longint se = e[lw-1] ? (e | ~mask) : e;
          r = (se >>> sh) & mask;
        end
        2'd2: r = e >> sh;
        default: r = e[lw-1] ? ((-e) & mask) : e;
      endcase
      rv[63:0] = r;
      res = res | (rv << (l * lw));
    end
    return res;
  endfunction

  function automatic logic [W-1:0] fill(logic [31:0] word);
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = word;
    return v;
  endfunction

  function automatic logic [W-1:0] rndVec();
    logic [W-1:0] v;
    for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [4:0] amt, logic [1:0] op,
                       logic [1:0] sz, string tag);
    item_t it;
    @(negedge clk);
    vecIn = a; shiftAmt = amt; opSel = op; sizeSel = sz; validIn = 1'b1;
    it.exp = refModel(a, amt, op, sz);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && validOut) begin
        item_t it;
        nChk++;
        if (q.size() == 0) begin
          nFail++;
          $display("FAIL R8: validOut high with nothing expected (actual 1, expected 0)");
        end else begin
          it = q.pop_front();
          if (vecOut !== it.exp) begin
            nFail++;
            $display("FAIL %s: actual %h expected %h", it.tag, vecOut, it.exp);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R8: watchdog expired (actual hung, expected completion)");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    logic [W-1:0] tenBit;
    repeat (3) @(negedge clk);
    // R9 reset state
    nChk++;
    if (validOut !== 1'b0 || vecOut !== '0) begin
      nFail++;
      $display("FAIL R9: actual valid=%b out=%h expected valid=0 out=0", validOut, vecOut);
    end
    @(negedge clk);
    rst = 1'b0;

    // R5 most negative values wrap
    drive(fill(32'h8080_8080), 5'd0, 2'd3, 2'd0, "R5");
    drive(fill(32'h8000_8000), 5'd7, 2'd3, 2'd1, "R5");
    drive(fill(32'h8000_0000), 5'd3, 2'd3, 2'd2, "R5");
    // R4 mixed signs, shift count ignored
    drive(fill(32'hFF01_807F), 5'd9, 2'd3, 2'd0, "R4");
    drive(fill(32'hFFFE_0002), 5'd31, 2'd3, 2'd1, "R4");
    // R7 lane isolation on all-ones
    for (int s = 0; s < 3; s++) begin
      drive(fill(32'hFFFF_FFFF), 5'd3, 2'd2, 2'(s), "R7");
      drive(fill(32'hFFFF_FFFF), 5'd3, 2'd0, 2'(s), "R7");
    end
    drive(fill(32'h8000_0001), 5'd4, 2'd1, 2'd3, "R7");
    // R6 count reduced modulo lane width
    drive(fill(32'h8181_8181), 5'd9, 2'd0, 2'd0, "R6");
    drive(fill(32'h8001_8001), 5'd17, 2'd1, 2'd1, "R6");
    drive(fill(32'h8000_0001), 5'd31, 2'd1, 2'd2, "R6");
    drive(fill(32'h8421_8421), 5'd16, 2'd2, 2'd1, "R6");
    // R10 10-bit to 8-bit on halfword lanes
    tenBit = '0;
    for (int l = 0; l < W / 16; l++) tenBit[l*16 +: 16] = 16'(($urandom % 1024));
    drive(tenBit, 5'd2, 2'd2, 2'd1, "R10");
    // R3 sign fill
    drive(fill(32'h80F0_7F0F), 5'd3, 2'd1, 2'd0, "R3");
    drive(fill(32'h9000_4000), 5'd5, 2'd1, 2'd1, "R3");
    // random sweep: R1 R2 R3 R4 per opcode
    for (int s = 0; s < 3; s++) begin
      for (int o = 0; o < 4; o++) begin
        for (int n = 0; n < 12; n++) begin
          string tag = (o == 0) ? "R1" : (o == 1) ? "R3" : (o == 2) ? "R2" : "R4";
          drive(rndVec(), 5'($urandom), 2'(o), 2'(s), tag);
        end
      end
    end
    @(negedge clk);
    validIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R8 hold while idle
    held = vecOut;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      vecIn = rndVec(); opSel = 2'(i); shiftAmt = 5'(i + 1);
    end
    @(negedge clk);
    nChk++;
    if (vecOut !== held || validOut !== 1'b0) begin
      nFail++;
      $display("FAIL R8: idle actual valid=%b out=%h expected valid=0 out=%h",
               validOut, vecOut, held);
    end
    if (q.size() != 0) begin
      nFail++;
      $display("FAIL R8: actual %0d results missing, expected 0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule